// File: doc/BRIEF.md
# PLL Power and Retune Sequencer

This block drives the control bits of a fractional-N PLL through three fixed sequences: bringing it up, taking it down, and changing its frequency. A host raises one of three one-cycle request lines. Retune requests also carry a new feedback word and a post-divider code. The sequencer then steps the power, isolation, enable, extra-enable, tuner-enable and reset-release outputs in a set order, with settling waits between some of the steps. The waits are counted in cycles of a reference clock whose frequency in MHz is a parameter.

During a retune the tuner is switched off first. The new post-divider and feedback word are then applied, either in one update or in two, depending on whether the two fields share a register. A one-cycle change strobe follows. Next, the tuner word is loaded with the new feedback word plus one, the tuner is switched back on, and a settling wait runs. `busy` is high for the whole of a sequence, and `done` pulses for one cycle at its end. Requests that arrive while a sequence is running are dropped.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, `pwr_on`=0, `iso_on`=1, `pll_en`=0, `xtra_en`=0, `tune_en`=0, `rst_rel`=0, `fbw`=FBW_RST, `pdiv`=0, `tune_word`=0, `fbw_chg`=0, `busy`=0 and `done`=0.
- R2: An up request accepted at clock edge k sets `pwr_on` at edge k. It clears `iso_on` at edge k+W1 and sets `pll_en` at edge k+2·W1, where W1 = REF_MHZ·PWR_US.
- R3: One edge after `pll_en` rises, `xtra_en` (when HAS_XTRA_EN=1) and `tune_en` rise. W2 = REF_MHZ·SETTLE_US edges later, `rst_rel` rises (when HAS_RST_REL=1). `busy` falls at that same edge.
- R4: A down request accepted at edge k changes one output per edge, in this order: `rst_rel` cleared (k), `tune_en` cleared (k+1), `xtra_en` cleared (k+2), `pll_en` cleared (k+3), `iso_on` set (k+4), `pwr_on` cleared (k+5). There are no waits between these steps.
- R5: A retune request accepted at edge k clears `tune_en` at edge k and captures `new_fbw` and `new_pdiv`. When SHARED_WORD=1, `pdiv` and `fbw` both update at edge k+1. When SHARED_WORD=0, `pdiv` updates at edge k+1 and `fbw` at edge k+2. `pdiv` is the 3-bit code k that selects division by 2^k.
- R6: The edge after the feedback word is written, `fbw_chg` rises for exactly one cycle. The next edge loads `tune_word` with `fbw`+1, taken modulo 2^FB_W. The edge after that sets `tune_en`, and `busy` falls W2 edges later.
- R7: `busy` is high from the accepting edge until the final edge of a sequence. `done` is high for exactly one cycle, starting at the edge where `busy` falls.
- R8: Any request that arrives while `busy` is high, or in the final cycle of a sequence, is ignored. That sequence's timing and every output, including `fbw` and `pdiv`, are unaffected.
- R9: When several requests arrive together while idle, up is served first, then down, then retune.
- R10: `en_status` equals `pll_en` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_up | input | 1 | Start power-up sequence |
| req_down | input | 1 | Start power-down sequence |
| req_retune | input | 1 | Start frequency change |
| new_fbw | input | FB_W | Feedback word for retune |
| new_pdiv | input | 3 | Post-divider code for retune (divide by 2^code) |
| pwr_on | output | 1 | PLL power switch |
| iso_on | output | 1 | Output isolation (1 = isolated) |
| pll_en | output | 1 | PLL enable |
| xtra_en | output | 1 | Additional enable bits |
| tune_en | output | 1 | Tuner enable |
| rst_rel | output | 1 | Reset release to the PLL |
| fbw | output | FB_W | Applied feedback word |
| pdiv | output | 3 | Applied post-divider code |
| fbw_chg | output | 1 | One-cycle change strobe |
| tune_word | output | FB_W | Tuner word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| en_status | output | 1 | Mirror of the enable bit |

## Verification
The bench runs two instances side by side, one with split field updates and one with shared updates, so an off-by-one in the update ordering shows up as a one-cycle skew against the model. Several corner cases are covered. An all-ones feedback word checks that the tuner word wraps to zero; a design that widened the sum would differ. Requests that land mid-sequence, or in the final cycle of one, must be dropped; a design that accepted them would restart a sequence or corrupt the fields. Simultaneous requests check the priority order; a wrong order would run the down or retune sequence instead. A retune while powered down checks that the tuner is still re-enabled.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   localparam int PDIV_W = 3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UP_PWR,
      ST_UP_ISO,
      ST_UP_EN,
      ST_UP_SET,
      ST_DN_TUN,
      ST_DN_XEN,
      ST_DN_EN,
      ST_DN_ISO,
      ST_DN_PWR,
      ST_RT_PD,
      ST_RT_FB,
      ST_RT_CHG,
      ST_RT_TW,
      ST_RT_TEN,
      ST_RT_WAIT
   } seq_state_e;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_UP,
      CMD_DOWN,
      CMD_RETUNE
   } seq_cmd_e;

   typedef struct packed {
      logic pwr;
      logic iso;
      logic en;
      logic xen;
      logic ten;
      logic rrel;
   } pll_ctl_t;

   localparam pll_ctl_t CTL_RESET = '{pwr: 1'b0, iso: 1'b1, en: 1'b0,
                                      xen: 1'b0, ten: 1'b0, rrel: 1'b0};

   // cycles of a wait minus one: the timer counts down through zero
   function automatic int wait_load(input int mhz, input int us);
      return mhz * us - 1;
   endfunction

endpackage

// File: rtl/pll_seq_arb.sv
module pll_seq_arb
   import pll_seq_pkg::*;
(
   input  logic     up,
   input  logic     down,
   input  logic     retune,
   output seq_cmd_e cmd
);
   // fixed priority: up, then down, then retune
   always_comb begin
      if (up)          cmd = CMD_UP;
      else if (down)   cmd = CMD_DOWN;
      else if (retune) cmd = CMD_RETUNE;
      else             cmd = CMD_NONE;
   end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
   import pll_seq_pkg::*;
#(
   parameter int REF_MHZ     = 26,
   parameter int PWR_US      = 1,
   parameter int SETTLE_US   = 20,
   parameter bit HAS_XTRA_EN = 1'b1,
   parameter bit HAS_RST_REL = 1'b1,
   parameter bit SHARED_WORD = 1'b0,
   parameter int CNT_W       = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_cmd_e         cmd,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output pll_ctl_t         ctl,
   output logic             cap,
   output logic             wr_pd,
   output logic             wr_fb,
   output logic             chg_set,
   output logic             tw_load,
   output logic             busy,
   output logic             done
);
   localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(wait_load(REF_MHZ, PWR_US));
   localparam logic [CNT_W-1:0] LD_SET = CNT_W'(wait_load(REF_MHZ, SETTLE_US));

   seq_state_e state_q, state_d;
   pll_ctl_t   ctl_q, ctl_d;
   logic       done_q, done_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ctl_q   <= CTL_RESET;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         ctl_q   <= ctl_d;
         done_q  <= done_d;
      end
   end

   always_comb begin
      state_d  = state_q;
      ctl_d    = ctl_q;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap      = 1'b0;
      wr_pd    = 1'b0;
      wr_fb    = 1'b0;
      chg_set  = 1'b0;
      tw_load  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            unique case (cmd)
               CMD_UP: begin
                  ctl_d.pwr = 1'b1;
                  tmr_load  = 1'b1;
                  tmr_val   = LD_PWR;
                  state_d   = ST_UP_PWR;
               end
               CMD_DOWN: begin
                  ctl_d.rrel = 1'b0;
                  state_d    = ST_DN_TUN;
               end
               CMD_RETUNE: begin
                  ctl_d.ten = 1'b0;
                  cap       = 1'b1;
                  state_d   = ST_RT_PD;
               end
               default: ;
            endcase
         end
         ST_UP_PWR: if (tmr_zero) begin
            ctl_d.iso = 1'b0;
            tmr_load  = 1'b1;
            tmr_val   = LD_PWR;
            state_d   = ST_UP_ISO;
         end
         ST_UP_ISO: if (tmr_zero) begin
            ctl_d.en = 1'b1;
            state_d  = ST_UP_EN;
         end
         ST_UP_EN: begin
            ctl_d.xen = HAS_XTRA_EN;
            ctl_d.ten = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = LD_SET;
            state_d   = ST_UP_SET;
         end
         ST_UP_SET: if (tmr_zero) begin
            ctl_d.rrel = HAS_RST_REL;
            done_d     = 1'b1;
            state_d    = ST_IDLE;
         end
         ST_DN_TUN: begin
            ctl_d.ten = 1'b0;
            state_d   = ST_DN_XEN;
         end
         ST_DN_XEN: begin
            ctl_d.xen = 1'b0;
            state_d   = ST_DN_EN;
         end
         ST_DN_EN: begin
            ctl_d.en = 1'b0;
            state_d  = ST_DN_ISO;
         end
         ST_DN_ISO: begin
            ctl_d.iso = 1'b1;
            state_d   = ST_DN_PWR;
         end
         ST_DN_PWR: begin
            ctl_d.pwr = 1'b0;
            done_d    = 1'b1;
            state_d   = ST_IDLE;
         end
         ST_RT_PD: begin
            wr_pd   = 1'b1;
            state_d = SHARED_WORD ? ST_RT_CHG : ST_RT_FB;
         end
         ST_RT_FB: begin
            wr_fb   = 1'b1;
            state_d = ST_RT_CHG;
         end
         ST_RT_CHG: begin
            chg_set = 1'b1;
            state_d = ST_RT_TW;
         end
         ST_RT_TW: begin
            tw_load = 1'b1;
            state_d = ST_RT_TEN;
         end
         ST_RT_TEN: begin
            ctl_d.ten = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = LD_SET;
            state_d   = ST_RT_WAIT;
         end
         ST_RT_WAIT: if (tmr_zero) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign ctl  = ctl_q;
   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
endmodule

// File: rtl/pll_seq_divreg.sv
module pll_seq_divreg
   import pll_seq_pkg::*;
#(
   parameter int            FB_W        = 22,
   parameter bit            SHARED_WORD = 1'b0,
   parameter logic [FB_W-1:0] FBW_RST   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [FB_W-1:0]   new_fbw,
   input  logic [PDIV_W-1:0] new_pdiv,
   input  logic              wr_pd,
   input  logic              wr_fb,
   input  logic              chg_set,
   input  logic              tw_load,
   output logic [FB_W-1:0]   fbw,
   output logic [PDIV_W-1:0] pdiv,
   output logic              fbw_chg,
   output logic [FB_W-1:0]   tune_word
);
   logic [FB_W-1:0]   stg_fb_q;
   logic [PDIV_W-1:0] stg_pd_q;
   logic [FB_W-1:0]   fb_q, tw_q;
   logic [PDIV_W-1:0] pd_q;
   logic              chg_q;
   logic              fb_we;

   generate
      if (SHARED_WORD) begin : g_shared
         // both fields live in one word: one update carries both
         assign fb_we = wr_pd | wr_fb;
      end else begin : g_split
         assign fb_we = wr_fb;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_fb_q <= '0;
         stg_pd_q <= '0;
         fb_q     <= FBW_RST;
         pd_q     <= '0;
         tw_q     <= '0;
         chg_q    <= 1'b0;
      end else begin
         if (cap) begin
            stg_fb_q <= new_fbw;
            stg_pd_q <= new_pdiv;
         end
         if (wr_pd)   pd_q <= stg_pd_q;
         if (fb_we)   fb_q <= stg_fb_q;
         if (tw_load) tw_q <= fb_q + 1'b1;
         chg_q <= chg_set;
      end
   end

   assign fbw       = fb_q;
   assign pdiv      = pd_q;
   assign tune_word = tw_q;
   assign fbw_chg   = chg_q;
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
   import pll_seq_pkg::*;
#(
   parameter int              REF_MHZ     = 26,
   parameter int              PWR_US      = 1,
   parameter int              SETTLE_US   = 20,
   parameter int              FB_W        = 22,
   parameter bit              HAS_XTRA_EN = 1'b1,
   parameter bit              HAS_RST_REL = 1'b1,
   parameter bit              SHARED_WORD = 1'b0,
   parameter logic [FB_W-1:0] FBW_RST     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_up,
   input  logic              req_down,
   input  logic              req_retune,
   input  logic [FB_W-1:0]   new_fbw,
   input  logic [PDIV_W-1:0] new_pdiv,
   output logic              pwr_on,
   output logic              iso_on,
   output logic              pll_en,
   output logic              xtra_en,
   output logic              tune_en,
   output logic              rst_rel,
   output logic [FB_W-1:0]   fbw,
   output logic [PDIV_W-1:0] pdiv,
   output logic              fbw_chg,
   output logic [FB_W-1:0]   tune_word,
   output logic              busy,
   output logic              done,
   output logic              en_status
);
   localparam int MAX_US = (SETTLE_US > PWR_US) ? SETTLE_US : PWR_US;
   localparam int CNT_W  = $clog2(REF_MHZ * MAX_US) + 1;

   generate
      if (REF_MHZ < 1)                 begin : g_bad_ref  $error("REF_MHZ must be at least 1"); end
      if (PWR_US < 1 || SETTLE_US < 1) begin : g_bad_wait $error("waits must be at least 1 us"); end
      if (FB_W < 8 || FB_W > 32)       begin : g_bad_fbw  $error("FB_W must be 8..32"); end
   endgenerate

   seq_cmd_e         cmd;
   pll_ctl_t         ctl;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             cap, wr_pd, wr_fb, chg_set, tw_load;

   pll_seq_arb u_arb (
      .up     (req_up),
      .down   (req_down),
      .retune (req_retune),
      .cmd    (cmd)
   );

   pll_seq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   pll_seq_fsm #(
      .REF_MHZ     (REF_MHZ),
      .PWR_US      (PWR_US),
      .SETTLE_US   (SETTLE_US),
      .HAS_XTRA_EN (HAS_XTRA_EN),
      .HAS_RST_REL (HAS_RST_REL),
      .SHARED_WORD (SHARED_WORD),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .tmr_zero (tmr_zero),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .ctl      (ctl),
      .cap      (cap),
      .wr_pd    (wr_pd),
      .wr_fb    (wr_fb),
      .chg_set  (chg_set),
      .tw_load  (tw_load),
      .busy     (busy),
      .done     (done)
   );

   pll_seq_divreg #(
      .FB_W        (FB_W),
      .SHARED_WORD (SHARED_WORD),
      .FBW_RST     (FBW_RST)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap),
      .new_fbw   (new_fbw),
      .new_pdiv  (new_pdiv),
      .wr_pd     (wr_pd),
      .wr_fb     (wr_fb),
      .chg_set   (chg_set),
      .tw_load   (tw_load),
      .fbw       (fbw),
      .pdiv      (pdiv),
      .fbw_chg   (fbw_chg),
      .tune_word (tune_word)
   );

   assign pwr_on    = ctl.pwr;
   assign iso_on    = ctl.iso;
   assign pll_en    = ctl.en;
   assign tune_en   = ctl.ten;
   assign en_status = ctl.en;

   generate
      if (HAS_XTRA_EN) begin : g_xen
         assign xtra_en = ctl.xen;
      end else begin : g_no_xen
         assign xtra_en = 1'b0;
      end
      if (HAS_RST_REL) begin : g_rrel
         assign rst_rel = ctl.rrel;
      end else begin : g_no_rrel
         assign rst_rel = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
   parameter int FB_W = 22
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pwr_on,
   input logic            iso_on,
   input logic            pll_en,
   input logic            rst_rel,
   input logic            fbw_chg,
   input logic            busy,
   input logic            done,
   input logic [FB_W-1:0] fbw,
   input logic [FB_W-1:0] tune_word
);
   // R2: isolation is only released while power is on
   a_r2_iso_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      !iso_on |-> pwr_on);
   // R2: enable only while isolation is released
   a_r2_en_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> !iso_on);
   // R3: reset release only while enabled
   a_r3_rrel_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      rst_rel |-> pll_en);
   // R4: power drops only after isolation and with enable already cleared
   a_r4_pwr_drops_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_on) |-> (iso_on && !pll_en));
   // R6: change strobe lasts one cycle
   a_r6_chg_single: assert property (@(posedge clk) disable iff (!rst_n)
      fbw_chg |=> !fbw_chg);
   // R6: tuner word follows the strobe with word plus one
   a_r6_tw_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fbw_chg) |-> (tune_word == FB_W'(fbw + 1'b1)));
   // R7: done is a one-cycle pulse coinciding with idle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R8: feedback word never moves while idle
   a_r8_fbw_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(fbw));
endmodule

bind pll_seq_ctrl pll_seq_chk #(.FB_W(FB_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_on    (pwr_on),
   .iso_on    (iso_on),
   .pll_en    (pll_en),
   .rst_rel   (rst_rel),
   .fbw_chg   (fbw_chg),
   .busy      (busy),
   .done      (done),
   .fbw       (fbw),
   .tune_word (tune_word)
);

// File: tb/tb_pll_seq_ctrl.sv
module tb_pll_seq_ctrl;
   localparam int REF  = 4;
   localparam int FB_W = 22;
   localparam int W1   = REF * 1;
   localparam int W2   = REF * 20;

   typedef struct packed {
      logic pwr, iso, en, xen, ten, rrel, busy, done, chg, ens;
      logic [FB_W-1:0] fb;
      logic [FB_W-1:0] tw;
      logic [2:0]      pd;
   } snap_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_up = 1'b0, req_down = 1'b0, req_retune = 1'b0;
   logic [FB_W-1:0] new_fbw = '0;
   logic [2:0]      new_pdiv = '0;

   logic pw0, is0, en0, xe0, te0, rr0, fc0, bz0, dn0, es0;
   logic pw1, is1, en1, xe1, te1, rr1, fc1, bz1, dn1, es1;
   logic [FB_W-1:0] fb0, tw0, fb1, tw1;
   logic [2:0]      pd0, pd1;

   always #5 clk = ~clk;

   pll_seq_ctrl #(.REF_MHZ(REF), .FB_W(FB_W), .SHARED_WORD(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_down(req_down),
      .req_retune(req_retune), .new_fbw(new_fbw), .new_pdiv(new_pdiv),
      .pwr_on(pw0), .iso_on(is0), .pll_en(en0), .xtra_en(xe0), .tune_en(te0),
      .rst_rel(rr0), .fbw(fb0), .pdiv(pd0), .fbw_chg(fc0), .tune_word(tw0),
      .busy(bz0), .done(dn0), .en_status(es0));

   pll_seq_ctrl #(.REF_MHZ(REF), .FB_W(FB_W), .SHARED_WORD(1'b1)) dut_sh (
      .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_down(req_down),
      .req_retune(req_retune), .new_fbw(new_fbw), .new_pdiv(new_pdiv),
      .pwr_on(pw1), .iso_on(is1), .pll_en(en1), .xtra_en(xe1), .tune_en(te1),
      .rst_rel(rr1), .fbw(fb1), .pdiv(pd1), .fbw_chg(fc1), .tune_word(tw1),
      .busy(bz1), .done(dn1), .en_status(es1));

   snap_t act0, act1;
   always_comb act0 = '{pwr:pw0, iso:is0, en:en0, xen:xe0, ten:te0, rrel:rr0,
                        busy:bz0, done:dn0, chg:fc0, ens:es0, fb:fb0, tw:tw0, pd:pd0};
   always_comb act1 = '{pwr:pw1, iso:is1, en:en1, xen:xe1, ten:te1, rrel:rr1,
                        busy:bz1, done:dn1, chg:fc1, ens:es1, fb:fb1, tw:tw1, pd:pd1};

   snap_t q0[$], q1[$];
   snap_t mdl[2];
   int    checks = 0, errors = 0;
   string tag = "R1 reset";

   function automatic int qsize(input int i);
      return (i == 0) ? q0.size() : q1.size();
   endfunction

   task automatic push(input int i, input snap_t s);
      if (i == 0) q0.push_back(s); else q1.push_back(s);
   endtask

   task automatic build_up(input int i);
      snap_t s = mdl[i];
      s.busy = 1; s.pwr = 1; push(i, s);
      for (int n = 1; n < W1; n++) push(i, s);
      s.iso = 0; push(i, s);
      for (int n = 1; n < W1; n++) push(i, s);
      s.en = 1; s.ens = 1; push(i, s);
      s.xen = 1; s.ten = 1; push(i, s);
      for (int n = 1; n < W2; n++) push(i, s);
      s.rrel = 1; s.busy = 0; s.done = 1; push(i, s);
      s.done = 0; mdl[i] = s;
   endtask

   task automatic build_down(input int i);
      snap_t s = mdl[i];
      s.busy = 1; s.rrel = 0; push(i, s);
      s.ten = 0; push(i, s);
      s.xen = 0; push(i, s);
      s.en = 0; s.ens = 0; push(i, s);
      s.iso = 1; push(i, s);
      s.pwr = 0; s.busy = 0; s.done = 1; push(i, s);
      s.done = 0; mdl[i] = s;
   endtask

   task automatic build_retune(input int i, input logic [FB_W-1:0] f, input logic [2:0] p);
      snap_t s = mdl[i];
      s.busy = 1; s.ten = 0; push(i, s);
      if (i == 1) begin
         s.pd = p; s.fb = f; push(i, s);
      end else begin
         s.pd = p; push(i, s);
         s.fb = f; push(i, s);
      end
      s.chg = 1; push(i, s);
      s.chg = 0; s.tw = s.fb + 1'b1; push(i, s);
      s.ten = 1; push(i, s);
      for (int n = 1; n < W2; n++) push(i, s);
      s.busy = 0; s.done = 1; push(i, s);
      s.done = 0; mdl[i] = s;
   endtask

   // call at a falling edge; request lasts one cycle
   task automatic issue(input bit up, input bit dn, input bit rt,
                        input logic [FB_W-1:0] f, input logic [2:0] p);
      req_up = up; req_down = dn; req_retune = rt; new_fbw = f; new_pdiv = p;
      for (int i = 0; i < 2; i++) begin
         if (qsize(i) == 0) begin
            if (up)      build_up(i);
            else if (dn) build_down(i);
            else if (rt) build_retune(i, f, p);
         end
      end
      @(negedge clk);
      req_up = 0; req_down = 0; req_retune = 0;
   endtask

   task automatic wait_idle();
      while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic compare(input int i, input snap_t a);
      snap_t e;
      if (i == 0) e = (q0.size() != 0) ? q0.pop_front() : mdl[0];
      else        e = (q1.size() != 0) ? q1.pop_front() : mdl[1];
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s inst%0d act=%h exp=%h", tag, i, a, e);
      end
   endtask

   task automatic chk(input bit ok, input string t, input int a, input int e);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", t, a, e);
      end
   endtask

   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk); #1;
         compare(0, act0);
         compare(1, act1);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      mdl[0] = '{pwr:0, iso:1, en:0, xen:0, ten:0, rrel:0, busy:0, done:0,
                 chg:0, ens:0, fb:'0, tw:'0, pd:'0};
      mdl[1] = mdl[0];
      repeat (3) @(negedge clk);
      // R1: reset values
      compare(0, act0);
      compare(1, act1);
      rst_n = 1'b1;
      @(negedge clk);

      tag = "R9 priority up-over-all, R2/R3 power-up";
      issue(1, 1, 1, 22'h0AAAAA, 3'd5);
      wait_idle();
      chk(es0 == 1'b1 && en0 == 1'b1, "R10 status after up", es0, 1);
      chk(fb0 == '0 && pd0 == 3'd0, "R9 retune not taken with up", fb0, 0);

      tag = "R5/R6 retune split vs shared";
      issue(0, 0, 1, 22'h012345, 3'd2);
      repeat (3) @(negedge clk);
      tag = "R8 requests while busy";
      issue(1, 1, 1, 22'h3FFF00, 3'd6);
      wait_idle();
      chk(pd0 == 3'd2, "R5 pdiv code", pd0, 2);

      tag = "R6 tuner word wrap";
      issue(0, 0, 1, 22'h3FFFFF, 3'd7);
      wait_idle();
      chk(tw0 == '0 && tw1 == '0, "R6 wrap to zero", tw0, 0);

      tag = "R9 down over retune, R4 power-down";
      issue(0, 1, 1, 22'h000111, 3'd1);
      wait_idle();
      chk(es0 == 1'b0 && is0 == 1'b1, "R10 status after down", es0, 0);

      tag = "R5 retune while powered down";
      issue(0, 0, 1, 22'h000003, 3'd0);
      wait_idle();

      tag = "R7 busy/done over power-up";
      issue(1, 0, 0, '0, '0);
      for (int n = 0; n < 2 * W1 + W2 - 1; n++) @(negedge clk);
      tag = "R8 request in final cycle";
      issue(0, 1, 0, '0, '0);
      wait_idle();
      chk(pw0 == 1'b1 && rr0 == 1'b1, "R8 final-cycle down ignored", pw0, 1);

      tag = "R4 final power-down";
      issue(0, 1, 0, '0, '0);
      wait_idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule